// File: doc/BRIEF.md
# Thread Block Warp Allocator

This block sits in front of one multiprocessor and decides when a waiting thread block may become resident. A block request carries its thread count and its needs for shared memory, registers per warp and barriers. The request is taken only when every pool can cover it at once and a resident-block slot is free. On acceptance the block's warps are created and placed across the sub-partitions in a rotating order.

Each warp keeps its sub-partition and slot until it retires. A warp's exit is latched when it arrives. The warp's slot and registers return to the pools once the warp has no instructions still in flight. Shared memory, barriers and the block slot return only when the last warp of the block retires, and at that point a one-cycle completion pulse is raised for the block slot.

Top module: `tbwa_top`

## Requirements
- R1: A request is accepted (`req_ready` high while `req_valid` is high) only if shared memory, barriers, registers (registers per warp times warp count), a warp slot on every sub-partition for its share of warps, and a free block slot are all available together. Otherwise `req_ready` stays low, the request is held, and no warp or resource is taken.
- R2: The warp count of a block is the thread count divided by 32, rounded up; a thread count of zero yields one warp.
- R3: Warp k of an accepted block (k from 0) goes to sub-partition (p + k) mod NUM_SUB, where p is a rotation pointer that starts at 0 after reset and advances by the warp count of every accepted block. Within a sub-partition the lowest free local slots are used. Warp index g = sub-partition × SUB_WARPS + local slot, and bit g of `warp_active` is high while that warp is resident.
- R4: An accepted block takes the lowest-numbered free block slot, and each of its warps reports that slot on `warp_block[g*BLK_W +: BLK_W]`.
- R5: A pulse on `warp_exit[g]` for a resident warp is remembered; the warp is released in the first cycle in which it has exited and `warp_busy[g]` is low, and stays resident while `warp_busy[g]` is high.
- R6: A pulse on `warp_exit[g]` while warp g is not resident has no effect, including on a warp later placed in that slot.
- R7: A block slot is freed only when its last warp is released; `blk_done[b]` is high for exactly one cycle, the cycle after that release edge. Releasing some but not all warps of a block raises no completion.
- R8: After reset no warp is resident, no block slot is in use, all pools are full and `blk_done` is zero.
- R9: Resources freed by a completed block are usable by a held request in the cycle right after the completion pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Block request present |
| req_ready | output | 1 | Request fits and is taken at this edge when valid |
| req_threads | input | THR_W | Threads in the requested block |
| req_smem | input | SMEM_W | Shared memory units needed by the block |
| req_regs | input | RPW_W | Registers needed per warp |
| req_bars | input | BAR_W | Barriers needed by the block |
| warp_exit | input | NW | Pulse: all threads of warp g have finished |
| warp_busy | input | NW | Warp g still has instructions in flight |
| warp_active | output | NW | Warp g is resident |
| warp_block | output | NW*BLK_W | Block slot owning each warp |
| blk_done | output | MAX_BLOCKS | One-cycle pulse when a block slot completes |

## Verification
A fixed list of requests is fed from reset: small blocks whose warps wrap around the sub-partitions, a five-warp block that lands two warps on one sub-partition, and requests that fail on shared memory, on barriers, on registers and on block slots one at a time, which separates each pool's contribution to the admission decision. Directed sequences then hold a warp resident behind in-flight instructions, retire a block partially and then completely, send an exit to an empty slot that is later reused, and keep a request waiting until a completing block frees the slot it needs. The placement checks after a completed block confirm that the rotation pointer carries over between blocks and that released slots are reused lowest first.

// File: rtl/tbwa_pkg.sv
package tbwa_pkg;

  localparam int unsigned LANES = 32;

  // Warps needed to cover a thread count; an empty block still gets one warp.
  function automatic int unsigned warps_for(input int unsigned threads);
    int unsigned n;
    n = (threads + LANES - 1) / LANES;
    return (n == 0) ? 1 : n;
  endfunction

  // Warps of a block landing on sub-partition s when rotation starts at ptr.
  function automatic int unsigned sub_share(input int unsigned nw, input int unsigned ptr,
                                            input int unsigned s, input int unsigned ns);
    int unsigned off;
    off = (s + ns - ptr) % ns;
    return nw / ns + ((off < (nw % ns)) ? 1 : 0);
  endfunction

endpackage

// File: rtl/tbwa_admit.sv
module tbwa_admit
  import tbwa_pkg::*;
#(
  parameter int NUM_SUB    = 4,
  parameter int SUB_WARPS  = 4,
  parameter int MAX_BLOCKS = 4,
  parameter int THR_W      = 10,
  parameter int SMEM_W     = 7,
  parameter int REG_W      = 11,
  parameter int BAR_W      = 4,
  parameter int RPW_W      = 8,
  localparam int NW    = NUM_SUB * SUB_WARPS,
  localparam int SUB_W = $clog2(NUM_SUB),
  localparam int BLK_W = $clog2(MAX_BLOCKS),
  localparam int WC_W  = THR_W - 4,
  localparam int RN_W  = RPW_W + WC_W
) (
  input  logic [THR_W-1:0]      threads,
  input  logic [SMEM_W-1:0]     smem,
  input  logic [RPW_W-1:0]      regs,
  input  logic [BAR_W-1:0]      bars,
  input  logic [NW-1:0]         active,
  input  logic [SUB_W-1:0]      ptr,
  input  logic [SMEM_W-1:0]     smem_free,
  input  logic [REG_W-1:0]      reg_free,
  input  logic [BAR_W-1:0]      bar_free,
  input  logic [MAX_BLOCKS-1:0] blk_busy,
  output logic                  fit,
  output logic [NW-1:0]         pick,
  output logic [BLK_W-1:0]      blk_sel,
  output logic [WC_W-1:0]       nwarps,
  output logic [RN_W-1:0]       reg_need
);

  logic [NUM_SUB-1:0] sub_ok;
  logic               blk_any;

  assign nwarps   = WC_W'(warps_for(32'(threads)));
  assign reg_need = RN_W'(regs) * RN_W'(nwarps);

  // Per sub-partition: count free slots and claim the lowest ones for its share.
  always_comb begin
    int unsigned need, have, taken;
    pick   = '0;
    sub_ok = '1;
    for (int s = 0; s < NUM_SUB; s++) begin
      need  = sub_share(32'(nwarps), 32'(ptr), s, NUM_SUB);
      have  = 0;
      taken = 0;
      for (int l = 0; l < SUB_WARPS; l++) begin
        if (!active[s*SUB_WARPS + l]) begin
          have++;
          if (taken < need) begin
            pick[s*SUB_WARPS + l] = 1'b1;
            taken++;
          end
        end
      end
      if (have < need) sub_ok[s] = 1'b0;
    end
  end

  // Lowest free block slot.
  always_comb begin
    blk_sel = '0;
    blk_any = 1'b0;
    for (int b = MAX_BLOCKS - 1; b >= 0; b--) begin
      if (!blk_busy[b]) begin
        blk_sel = BLK_W'(b);
        blk_any = 1'b1;
      end
    end
  end

  assign fit = (&sub_ok) && blk_any && (smem <= smem_free) && (bars <= bar_free)
               && (32'(reg_need) <= 32'(reg_free));

endmodule

// File: rtl/tbwa_warp_table.sv
module tbwa_warp_table #(
  parameter int NUM_SUB    = 4,
  parameter int SUB_WARPS  = 4,
  parameter int MAX_BLOCKS = 4,
  parameter int REG_W      = 11,
  parameter int RPW_W      = 8,
  localparam int NW    = NUM_SUB * SUB_WARPS,
  localparam int BLK_W = $clog2(MAX_BLOCKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc,
  input  logic [NW-1:0]       pick,
  input  logic [BLK_W-1:0]    alloc_blk,
  input  logic [RPW_W-1:0]    alloc_regs,
  input  logic [NW-1:0]       warp_exit,
  input  logic [NW-1:0]       warp_busy,
  output logic [NW-1:0]       active,
  output logic [NW*BLK_W-1:0] wblk,
  output logic [NW-1:0]       release_w,
  output logic [REG_W-1:0]    freed_regs
);

  logic [NW-1:0]    active_q, fin_q;
  logic [RPW_W-1:0] rpw_q [NW];

  assign active    = active_q;
  assign release_w = active_q & (fin_q | warp_exit) & ~warp_busy;

  always_comb begin
    freed_regs = '0;
    for (int i = 0; i < NW; i++)
      if (release_w[i]) freed_regs = freed_regs + REG_W'(rpw_q[i]);
  end

  for (genvar i = 0; i < NW; i++) begin : g_warp
    logic [BLK_W-1:0] blk_q;
    assign wblk[i*BLK_W +: BLK_W] = blk_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active_q[i] <= 1'b0;
        fin_q[i]    <= 1'b0;
        blk_q       <= '0;
        rpw_q[i]    <= '0;
      end else if (alloc && pick[i]) begin
        active_q[i] <= 1'b1;
        fin_q[i]    <= 1'b0;
        blk_q       <= alloc_blk;
        rpw_q[i]    <= alloc_regs;
      end else if (release_w[i]) begin
        active_q[i] <= 1'b0;
        fin_q[i]    <= 1'b0;
      end else if (active_q[i] && warp_exit[i]) begin
        fin_q[i]    <= 1'b1;
      end
    end

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q[i] && warp_busy[i]) |=> active_q[i]);

    // R6
    idle_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q[i] |-> !fin_q[i]);
  end

  // R3
  pick_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> ((pick & active_q) == '0));

endmodule

// File: rtl/tbwa_block_table.sv
module tbwa_block_table #(
  parameter int NUM_SUB    = 4,
  parameter int SUB_WARPS  = 4,
  parameter int MAX_BLOCKS = 4,
  parameter int SMEM_W     = 7,
  parameter int BAR_W      = 4,
  parameter int WC_W       = 6,
  localparam int NW    = NUM_SUB * SUB_WARPS,
  localparam int BLK_W = $clog2(MAX_BLOCKS),
  localparam int CNT_W = $clog2(NW + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc,
  input  logic [BLK_W-1:0]      alloc_blk,
  input  logic [WC_W-1:0]       alloc_cnt,
  input  logic [SMEM_W-1:0]     alloc_smem,
  input  logic [BAR_W-1:0]      alloc_bars,
  input  logic [NW-1:0]         release_w,
  input  logic [NW*BLK_W-1:0]   wblk,
  output logic [MAX_BLOCKS-1:0] busy,
  output logic [MAX_BLOCKS-1:0] done,
  output logic [SMEM_W-1:0]     freed_smem,
  output logic [BAR_W-1:0]      freed_bars
);

  logic [CNT_W-1:0]      dec    [MAX_BLOCKS];
  logic [CNT_W-1:0]      remain [MAX_BLOCKS];
  logic [SMEM_W-1:0]     smem_q [MAX_BLOCKS];
  logic [BAR_W-1:0]      bars_q [MAX_BLOCKS];
  logic [MAX_BLOCKS-1:0] finish, busy_q, done_q;

  assign busy = busy_q;
  assign done = done_q;

  always_comb begin
    for (int b = 0; b < MAX_BLOCKS; b++) begin
      dec[b] = '0;
      for (int i = 0; i < NW; i++)
        if (release_w[i] && wblk[i*BLK_W +: BLK_W] == BLK_W'(b)) dec[b] = dec[b] + 1'b1;
    end
  end

  always_comb begin
    freed_smem = '0;
    freed_bars = '0;
    for (int b = 0; b < MAX_BLOCKS; b++) begin
      finish[b] = busy_q[b] && (dec[b] != '0) && (dec[b] == remain[b]);
      if (finish[b]) begin
        freed_smem = freed_smem + smem_q[b];
        freed_bars = freed_bars + bars_q[b];
      end
    end
  end

  for (genvar b = 0; b < MAX_BLOCKS; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[b] <= 1'b0;
        done_q[b] <= 1'b0;
        remain[b] <= '0;
        smem_q[b] <= '0;
        bars_q[b] <= '0;
      end else begin
        done_q[b] <= finish[b];
        if (alloc && alloc_blk == BLK_W'(b)) begin
          busy_q[b] <= 1'b1;
          remain[b] <= CNT_W'(alloc_cnt);
          smem_q[b] <= alloc_smem;
          bars_q[b] <= alloc_bars;
        end else if (finish[b]) begin
          busy_q[b] <= 1'b0;
          remain[b] <= '0;
        end else begin
          remain[b] <= remain[b] - dec[b];
        end
      end
    end

    // R7
    remain_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[b] |-> (dec[b] <= remain[b]));
  end

  // R7
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != '0) |-> ((done_q & busy_q) == '0));

endmodule

// File: rtl/tbwa_top.sv
module tbwa_top #(
  parameter int NUM_SUB    = 4,
  parameter int SUB_WARPS  = 4,
  parameter int MAX_BLOCKS = 4,
  parameter int THR_W      = 10,
  parameter int SMEM_UNITS = 64,
  parameter int REG_UNITS  = 1024,
  parameter int BAR_UNITS  = 8,
  parameter int RPW_W      = 8,
  localparam int NW     = NUM_SUB * SUB_WARPS,
  localparam int SUB_W  = $clog2(NUM_SUB),
  localparam int BLK_W  = $clog2(MAX_BLOCKS),
  localparam int SMEM_W = $clog2(SMEM_UNITS + 1),
  localparam int REG_W  = $clog2(REG_UNITS + 1),
  localparam int BAR_W  = $clog2(BAR_UNITS + 1),
  localparam int WC_W   = THR_W - 4,
  localparam int RN_W   = RPW_W + WC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [THR_W-1:0]      req_threads,
  input  logic [SMEM_W-1:0]     req_smem,
  input  logic [RPW_W-1:0]      req_regs,
  input  logic [BAR_W-1:0]      req_bars,
  input  logic [NW-1:0]         warp_exit,
  input  logic [NW-1:0]         warp_busy,
  output logic [NW-1:0]         warp_active,
  output logic [NW*BLK_W-1:0]   warp_block,
  output logic [MAX_BLOCKS-1:0] blk_done
);

  logic [SUB_W-1:0]      ptr_q;
  logic [SMEM_W-1:0]     smem_free_q, freed_smem;
  logic [REG_W-1:0]      reg_free_q, freed_regs;
  logic [BAR_W-1:0]      bar_free_q, freed_bars;
  logic [MAX_BLOCKS-1:0] blk_busy;
  logic [NW-1:0]         pick, release_w;
  logic [BLK_W-1:0]      blk_sel;
  logic [WC_W-1:0]       nwarps;
  logic [RN_W-1:0]       reg_need;
  logic                  fit, accept;

  assign req_ready = fit;
  assign accept    = req_valid && fit;

  tbwa_admit #(
    .NUM_SUB(NUM_SUB), .SUB_WARPS(SUB_WARPS), .MAX_BLOCKS(MAX_BLOCKS), .THR_W(THR_W),
    .SMEM_W(SMEM_W), .REG_W(REG_W), .BAR_W(BAR_W), .RPW_W(RPW_W)
  ) u_admit (
    .threads(req_threads), .smem(req_smem), .regs(req_regs), .bars(req_bars),
    .active(warp_active), .ptr(ptr_q), .smem_free(smem_free_q), .reg_free(reg_free_q),
    .bar_free(bar_free_q), .blk_busy(blk_busy), .fit(fit), .pick(pick),
    .blk_sel(blk_sel), .nwarps(nwarps), .reg_need(reg_need)
  );

  tbwa_warp_table #(
    .NUM_SUB(NUM_SUB), .SUB_WARPS(SUB_WARPS), .MAX_BLOCKS(MAX_BLOCKS),
    .REG_W(REG_W), .RPW_W(RPW_W)
  ) u_warps (
    .clk(clk), .rst_n(rst_n), .alloc(accept), .pick(pick), .alloc_blk(blk_sel),
    .alloc_regs(req_regs), .warp_exit(warp_exit), .warp_busy(warp_busy),
    .active(warp_active), .wblk(warp_block), .release_w(release_w), .freed_regs(freed_regs)
  );

  tbwa_block_table #(
    .NUM_SUB(NUM_SUB), .SUB_WARPS(SUB_WARPS), .MAX_BLOCKS(MAX_BLOCKS),
    .SMEM_W(SMEM_W), .BAR_W(BAR_W), .WC_W(WC_W)
  ) u_blocks (
    .clk(clk), .rst_n(rst_n), .alloc(accept), .alloc_blk(blk_sel), .alloc_cnt(nwarps),
    .alloc_smem(req_smem), .alloc_bars(req_bars), .release_w(release_w), .wblk(warp_block),
    .busy(blk_busy), .done(blk_done), .freed_smem(freed_smem), .freed_bars(freed_bars)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      smem_free_q <= SMEM_W'(SMEM_UNITS);
      reg_free_q  <= REG_W'(REG_UNITS);
      bar_free_q  <= BAR_W'(BAR_UNITS);
    end else begin
      if (accept) ptr_q <= SUB_W'((32'(ptr_q) + 32'(nwarps)) % NUM_SUB);
      smem_free_q <= smem_free_q - (accept ? req_smem : '0) + freed_smem;
      reg_free_q  <= reg_free_q - (accept ? REG_W'(reg_need) : '0) + freed_regs;
      bar_free_q  <= bar_free_q - (accept ? req_bars : '0) + freed_bars;
    end
  end

  // R1
  pick_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($countones(pick) == int'(nwarps)));

  // R1
  smem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smem_free_q <= SMEM_W'(SMEM_UNITS));

  // R1
  reg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_free_q <= REG_W'(REG_UNITS));

  // R1
  bar_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_free_q <= BAR_W'(BAR_UNITS));

endmodule

// File: tb/test_tbwa_top.sv
`timescale 1ns/1ps
module test_tbwa_top;

  localparam int NW = 16;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [9:0]    req_threads;
  logic [6:0]    req_smem;
  logic [7:0]    req_regs;
  logic [3:0]    req_bars;
  logic [NW-1:0] warp_exit, warp_busy, warp_active;
  logic [NW*BW-1:0] warp_block;
  logic [3:0]    blk_done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  logic [15:0] act;

  always #2 clk = ~clk;

  tbwa_top i_tbwa_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_smem(req_smem), .req_regs(req_regs), .req_bars(req_bars),
    .warp_exit(warp_exit), .warp_busy(warp_busy), .warp_active(warp_active),
    .warp_block(warp_block), .blk_done(blk_done)
  );

  typedef struct packed {
    logic [9:0]  thr;
    logic [6:0]  smem;
    logic [7:0]  regs;
    logic [3:0]  bars;
    logic        acc;
    logic [15:0] mask;
  } vec_t;

  // From reset, pointer 0; warp index = sub*4 + local slot.
  localparam vec_t VEC [8] = '{
    '{10'd64,  7'd8,  8'd16,  4'd1, 1'b1, 16'h0011},  // R3 subs 0,1
    '{10'd33,  7'd8,  8'd16,  4'd1, 1'b1, 16'h1100},  // R2 33 threads -> 2 warps, subs 2,3
    '{10'd160, 7'd8,  8'd16,  4'd1, 1'b1, 16'h2226},  // R3 5 warps wrap, two on sub0
    '{10'd32,  7'd48, 8'd16,  4'd1, 1'b0, 16'h0000},  // R1 shared memory short
    '{10'd32,  7'd8,  8'd16,  4'd6, 1'b0, 16'h0000},  // R1 barriers short
    '{10'd128, 7'd8,  8'd255, 4'd1, 1'b0, 16'h0000},  // R1 registers short
    '{10'd32,  7'd8,  8'd16,  4'd1, 1'b1, 16'h0040},  // R3 pointer at 1
    '{10'd32,  7'd1,  8'd1,   4'd0, 1'b0, 16'h0000}   // R1 no block slot
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic drive_req(input logic [9:0] t, input logic [6:0] s, input logic [7:0] r,
                           input logic [3:0] b);
    req_valid = 1'b1; req_threads = t; req_smem = s; req_regs = r; req_bars = b;
  endtask

  // Pulse an exit mask at one edge, then check at the following negedge.
  task automatic exit_pulse(input logic [15:0] m);
    warp_exit = m;
    @(negedge clk);
    warp_exit = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_threads = '0; req_smem = '0; req_regs = '0;
    req_bars = '0; warp_exit = '0; warp_busy = '0; act = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 no resident warps", 32'(warp_active), 32'h0);
    chk("R8 no completion", 32'(blk_done), 32'h0);

    for (int v = 0; v < 8; v++) begin
      drive_req(VEC[v].thr, VEC[v].smem, VEC[v].regs, VEC[v].bars);
      #1;
      chk($sformatf("R1 ready vec%0d", v), 32'(req_ready), 32'(VEC[v].acc));
      @(negedge clk);
      req_valid = 1'b0;
      act = act | VEC[v].mask;
      chk($sformatf("R3 placement vec%0d", v), 32'(warp_active), 32'(act));
    end
    chk("R4 block of warp6", 32'(warp_block[6*BW +: BW]), 32'd3);
    chk("R4 block of warp9", 32'(warp_block[9*BW +: BW]), 32'd2);
    chk("R4 block of warp12", 32'(warp_block[12*BW +: BW]), 32'd1);

    // R5 warp 6 exits but has instructions in flight.
    warp_busy[6] = 1'b1;
    exit_pulse(16'h0040);
    @(negedge clk);
    chk("R5 held while busy", 32'(warp_active[6]), 32'd1);
    chk("R7 no done while busy", 32'(blk_done), 32'h0);
    warp_busy[6] = 1'b0;
    @(negedge clk);
    chk("R5 released after drain", 32'(warp_active), 32'h3337);
    chk("R7 block3 done pulse", 32'(blk_done), 32'h8);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(blk_done), 32'h0);

    // R7 partial retirement of block 2, then its last warp.
    exit_pulse(16'h0226);
    chk("R7 partial release", 32'(warp_active), 32'h3111);
    chk("R7 no done on partial", 32'(blk_done), 32'h0);
    exit_pulse(16'h2000);
    chk("R7 last warp release", 32'(warp_active), 32'h1111);
    chk("R7 block2 done pulse", 32'(blk_done), 32'h4);

    // R3 pointer carried at 2: subs 2,3, lowest free locals.
    drive_req(10'd64, 7'd8, 8'd16, 4'd1);
    #1 chk("R1 ready two warps", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 reuse lowest slots", 32'(warp_active), 32'h3311);
    chk("R4 reuse block slot 2", 32'(warp_block[13*BW +: BW]), 32'd2);

    // R1 sixteen warps cannot fit while sub-partitions hold warps.
    drive_req(10'd512, 7'd1, 8'd1, 4'd0);
    #1 chk("R1 warp slots short", 32'(req_ready), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 nothing taken", 32'(warp_active), 32'h3311);

    // R6 exit to empty slot 1 then reuse of that slot.
    exit_pulse(16'h0002);
    chk("R6 idle exit no effect", 32'(warp_active), 32'h3311);
    drive_req(10'd32, 7'd8, 8'd16, 4'd1);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 reused slot stays", 32'(warp_active), 32'h3313);
    chk("R4 block slot 3", 32'(warp_block[1*BW +: BW]), 32'd3);

    // R9 held request waits for a block slot; zero threads -> one warp (R2).
    drive_req(10'd0, 7'd8, 8'd16, 4'd1);
    #1 chk("R9 held no slot", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk("R9 still held", 32'(req_ready), 32'd0);
    chk("R9 nothing taken", 32'(warp_active), 32'h3313);
    exit_pulse(16'h0011);
    chk("R7 block0 done", 32'(blk_done), 32'h1);
    chk("R9 ready after free", 32'(req_ready), 32'd1);
    chk("R9 warps released", 32'(warp_active), 32'h3302);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 zero threads one warp", 32'(warp_active), 32'h3312);
    chk("R4 block slot 0 reused", 32'(warp_block[4*BW +: BW]), 32'd0);

    finish_run();
  end

endmodule